// File: doc/BRIEF.md
# Threshold-Based Counter Flush Controller

This block is the bookkeeping core of a two-tier statistics store. A bank of narrow, fast counters takes one increment per cycle, and a bank of wide, slow counters keeps the long-run totals. After a fixed number of accepted increments, called a window, the block moves exactly one narrow counter into its wide partner and clears it. Flushing often enough keeps the narrow counters short.

The victim is chosen without sorting. A window tracker remembers which counter held the largest post-increment value during the current window. A bitmap marks every narrow counter whose value has reached a threshold. If the tracked counter is at or above the threshold, it is flushed. Otherwise the lowest-indexed marked counter is flushed. If nothing is marked, the tracked counter is flushed anyway.

Each flush is reported on a flush port as an index and a value. The wide totals can be read at any time through a combinational read port. Both banks are internal register arrays.

Top module: `ctr_flush_ctrl`

## Requirements
- R1: After reset, every narrow and wide counter is zero, `flush_valid` is 0 and `ovf` is 0.
- R2: Each cycle with `inc_valid` high adds one to the narrow counter selected by `inc_idx`. A flushed value equals the increments that counter received since it was last cleared.
- R3: Exactly one flush happens per WIN accepted increments; idle cycles are not counted. For an increment taken at clock edge k, when it is the last of its window, the flush executes at edge k+1. `flush_valid` is high for one cycle after that edge.
- R4: The window's tracked counter is the one with the largest post-increment value in that window. On a tie, the counter that reached that value first is kept. Tracking restarts with the first increment of each window.
- R5: If the tracked counter's current value is at least THR when the flush executes, that counter is flushed.
- R6: If the tracked counter is below THR, the lowest-indexed counter whose value is at least THR is flushed. If no such counter exists, the tracked counter is flushed.
- R7: A flush presents the victim's narrow value on `flush_val` and its index on `flush_idx`, clears the narrow counter, and adds the value to the wide counter. The new total is visible on `rd_data` from the same cycle that `flush_valid` is high.
- R8: An increment to the victim index in the flush cycle is applied after the clear, so that counter holds 1 afterwards and no count is lost.
- R9: A narrow counter at its maximum (2^SW-1) that is incremented stays at the maximum. The increment sets `ovf`, which stays high until reset.
- R10: `rd_data` is the wide counter selected by `rd_idx`, read without a clock delay. Wide sums wrap modulo 2^WW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_valid | input | 1 | Increment request this cycle |
| inc_idx | input | $clog2(N) | Counter to increment |
| rd_idx | input | $clog2(N) | Wide counter to read |
| flush_valid | output | 1 | A flush completed at the last edge |
| flush_idx | output | $clog2(N) | Index of the flushed counter |
| flush_val | output | SW | Narrow value moved by the flush |
| rd_data | output | WW | Wide counter selected by `rd_idx` |
| ovf | output | 1 | Sticky saturation flag |

## Verification
Corruption of the window tracker or of the threshold bitmap shows up as a wrong `flush_idx` on the very next flush. That is at most WIN increments and one extra cycle later. A narrow counter that loses or gains counts is seen as a wrong `flush_val` when that counter is next chosen. The bench forces this quickly by concentrating traffic on a few indices. Wide-bank faults are exposed on `rd_data` in the same cycle as the flush that wrote them. An early or late window boundary shifts `flush_valid` by a cycle against the increment count.

// File: rtl/ctr_flush_pkg.sv
package ctr_flush_pkg;

  // next value of a saturating counter held in 32 bits
  function automatic int unsigned sat_next(input int unsigned cur, input int unsigned top);
    return (cur >= top) ? top : cur + 1;
  endfunction

  // membership rule of the threshold set
  function automatic logic over_thr(input int unsigned v, input int unsigned thr);
    return v >= thr;
  endfunction

endpackage

// File: rtl/ctr_flush_small_bank.sv
module ctr_flush_small_bank #(
  parameter int unsigned N   = 8,
  parameter int unsigned SW  = 3,
  parameter int unsigned THR = 3,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inc_valid,
  input  logic [IW-1:0]         inc_idx,
  input  logic                  clr_valid,
  input  logic [IW-1:0]         clr_idx,
  output logic [N-1:0][SW-1:0]  vals,
  output logic [N-1:0]          hot,
  output logic [SW-1:0]         inc_newval,
  output logic                  inc_sat,
  output logic                  ovf
);
  import ctr_flush_pkg::*;
  localparam int unsigned TOP = (1 << SW) - 1;

  logic [SW-1:0] base;

  always_comb begin
    base       = (clr_valid && clr_idx == inc_idx) ? '0 : vals[inc_idx];
    inc_newval = SW'(sat_next(32'(base), TOP));
    inc_sat    = inc_valid && (32'(base) == TOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vals <= '0;
      hot  <= '0;
      ovf  <= 1'b0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (inc_valid && inc_idx == IW'(i)) begin
          vals[i] <= inc_newval;
          hot[i]  <= over_thr(32'(inc_newval), THR);
        end else if (clr_valid && clr_idx == IW'(i)) begin
          vals[i] <= '0;
          hot[i]  <= 1'b0;
        end
      end
      if (inc_sat) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/ctr_flush_window.sv
module ctr_flush_window #(
  parameter int unsigned N   = 8,
  parameter int unsigned SW  = 3,
  parameter int unsigned WIN = 6,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned CW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_valid,
  input  logic [IW-1:0] inc_idx,
  input  logic [SW-1:0] inc_newval,
  output logic [IW-1:0] best_idx,
  output logic          win_done
);
  logic [CW-1:0] cnt;
  logic [SW-1:0] best_val;
  logic          first;

  always_comb begin
    first    = (cnt == '0);
    win_done = inc_valid && (32'(cnt) == WIN - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      best_idx <= '0;
      best_val <= '0;
    end else if (inc_valid) begin
      if (first || inc_newval > best_val) begin
        best_idx <= inc_idx;
        best_val <= inc_newval;
      end
      cnt <= win_done ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ctr_flush_victim.sv
module ctr_flush_victim #(
  parameter int unsigned N   = 8,
  parameter int unsigned SW  = 3,
  parameter int unsigned THR = 3,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [IW-1:0]        best_idx,
  input  logic [N-1:0][SW-1:0] vals,
  input  logic [N-1:0]         hot,
  output logic [IW-1:0]        victim,
  output logic [SW-1:0]        victim_val
);
  import ctr_flush_pkg::*;

  function automatic logic [IW-1:0] low_idx(input logic [N-1:0] m);
    logic [IW-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) if (m[k]) r = IW'(k);
    return r;
  endfunction

  always_comb begin
    if (over_thr(32'(vals[best_idx]), THR)) victim = best_idx;
    else if (|hot)                          victim = low_idx(hot);
    else                                    victim = best_idx;
    victim_val = vals[victim];
  end
endmodule

// File: rtl/ctr_flush_wide_bank.sv
module ctr_flush_wide_bank #(
  parameter int unsigned N  = 8,
  parameter int unsigned SW = 3,
  parameter int unsigned WW = 12,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_en,
  input  logic [IW-1:0] add_idx,
  input  logic [SW-1:0] add_val,
  input  logic [IW-1:0] rd_idx,
  output logic [WW-1:0] rd_data
);
  logic [N-1:0][WW-1:0] wide;

  function automatic logic [WW-1:0] wide_add(input logic [WW-1:0] a, input logic [SW-1:0] b);
    return a + WW'(b);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) wide <= '0;
    else if (add_en) wide[add_idx] <= wide_add(wide[add_idx], add_val);
  end

  assign rd_data = wide[rd_idx];
endmodule

// File: rtl/ctr_flush_ctrl.sv
module ctr_flush_ctrl #(
  parameter int unsigned N   = 8,
  parameter int unsigned SW  = 3,
  parameter int unsigned WW  = 12,
  parameter int unsigned WIN = 6,
  parameter int unsigned THR = 3,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_valid,
  input  logic [IW-1:0] inc_idx,
  input  logic [IW-1:0] rd_idx,
  output logic          flush_valid,
  output logic [IW-1:0] flush_idx,
  output logic [SW-1:0] flush_val,
  output logic [WW-1:0] rd_data,
  output logic          ovf
);
  logic [N-1:0][SW-1:0] vals;
  logic [N-1:0]         hot;
  logic [SW-1:0]        inc_newval;
  logic                 inc_sat;
  logic [IW-1:0]        best_idx;
  logic                 win_done;
  logic                 flush_go;
  logic [IW-1:0]        victim;
  logic [SW-1:0]        victim_val;

  ctr_flush_small_bank #(.N(N), .SW(SW), .THR(THR)) u_small (
    .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc_idx(inc_idx),
    .clr_valid(flush_go), .clr_idx(victim), .vals(vals), .hot(hot),
    .inc_newval(inc_newval), .inc_sat(inc_sat), .ovf(ovf));

  ctr_flush_window #(.N(N), .SW(SW), .WIN(WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc_idx(inc_idx),
    .inc_newval(inc_newval), .best_idx(best_idx), .win_done(win_done));

  ctr_flush_victim #(.N(N), .SW(SW), .THR(THR)) u_pick (
    .best_idx(best_idx), .vals(vals), .hot(hot),
    .victim(victim), .victim_val(victim_val));

  ctr_flush_wide_bank #(.N(N), .SW(SW), .WW(WW)) u_wide (
    .clk(clk), .rst_n(rst_n), .add_en(flush_go), .add_idx(victim),
    .add_val(victim_val), .rd_idx(rd_idx), .rd_data(rd_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_go    <= 1'b0;
      flush_valid <= 1'b0;
      flush_idx   <= '0;
      flush_val   <= '0;
    end else begin
      flush_go    <= win_done;
      flush_valid <= flush_go;
      if (flush_go) begin
        flush_idx <= victim;
        flush_val <= victim_val;
      end
    end
  end
endmodule

// File: rtl/ctr_flush_chk.sv
module ctr_flush_chk #(
  parameter int unsigned N   = 8,
  parameter int unsigned SW  = 3,
  parameter int unsigned THR = 3,
  localparam int unsigned IW = $clog2(N)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 inc_valid,
  input logic [IW-1:0]        inc_idx,
  input logic                 win_done,
  input logic                 flush_go,
  input logic                 flush_valid,
  input logic [IW-1:0]        best_idx,
  input logic [IW-1:0]        victim,
  input logic [N-1:0][SW-1:0] vals,
  input logic [N-1:0]         hot,
  input logic                 inc_sat,
  input logic                 ovf
);
  // R3: a completed window always leads to a flush on the next edge
  a_r3_flush_follows: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> flush_go);
  // R3: flush result is reported one cycle after the flush executes
  a_r3_report: assert property (@(posedge clk) disable iff (!rst_n)
    flush_go |=> flush_valid);
  // R5: tracked counter at or above threshold is the victim
  a_r5_tracked_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_go && 32'(vals[best_idx]) >= THR) |-> victim == best_idx);
  // R6: with tracked counter low and a marked counter present, victim is marked
  a_r6_marked_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_go && 32'(vals[best_idx]) < THR && (|hot)) |-> hot[victim]);
  // R7: flushed counter is zero afterwards when not also incremented
  a_r7_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_go && !(inc_valid && inc_idx == victim)) |=> vals[$past(victim)] == '0);
  // R8: flush-cycle increment to the victim leaves it at one
  a_r8_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_go && inc_valid && inc_idx == victim) |=> 32'(vals[$past(victim)]) == 1);
  // R9: saturation raises the flag, which then stays up
  a_r9_sat_flag: assert property (@(posedge clk) disable iff (!rst_n)
    inc_sat |=> ovf);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

bind ctr_flush_ctrl ctr_flush_chk #(.N(N), .SW(SW), .THR(THR)) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc_idx(inc_idx),
  .win_done(win_done), .flush_go(flush_go), .flush_valid(flush_valid),
  .best_idx(best_idx), .victim(victim), .vals(vals), .hot(hot),
  .inc_sat(inc_sat), .ovf(ovf));

// File: tb/ctr_flush_ctrl_tb.sv
module ctr_flush_ctrl_tb;
  localparam int N = 8, SW = 3, WW = 12, WIN = 6, THR = 3;
  localparam int TOP = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inc_valid = 1'b0;
  logic [2:0] inc_idx = '0;
  logic [2:0] rd_idx = '0;
  logic       flush_valid;
  logic [2:0] flush_idx;
  logic [2:0] flush_val;
  logic [11:0] rd_data;
  logic       ovf;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctr_flush_ctrl #(.N(N), .SW(SW), .WW(WW), .WIN(WIN), .THR(THR)) u_dut (
    .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc_idx(inc_idx),
    .rd_idx(rd_idx), .flush_valid(flush_valid), .flush_idx(flush_idx),
    .flush_val(flush_val), .rd_data(rd_data), .ovf(ovf));

  // {valid, idx, exp_flush, exp_idx, exp_val}
  localparam logic [10:0] VEC [0:32] = '{
    {1'b1,3'd0,1'b0,3'd0,3'd0}, {1'b1,3'd0,1'b0,3'd0,3'd0}, {1'b1,3'd0,1'b0,3'd0,3'd0},
    {1'b1,3'd5,1'b0,3'd0,3'd0}, {1'b1,3'd5,1'b0,3'd0,3'd0}, {1'b1,3'd5,1'b0,3'd0,3'd0},
    {1'b1,3'd2,1'b1,3'd0,3'd3}, {1'b1,3'd3,1'b0,3'd0,3'd0}, {1'b1,3'd2,1'b0,3'd0,3'd0},
    {1'b1,3'd3,1'b0,3'd0,3'd0}, {1'b1,3'd7,1'b0,3'd0,3'd0}, {1'b1,3'd7,1'b0,3'd0,3'd0},
    {1'b1,3'd2,1'b1,3'd5,3'd3}, {1'b1,3'd2,1'b0,3'd0,3'd0}, {1'b1,3'd2,1'b0,3'd0,3'd0},
    {1'b1,3'd2,1'b0,3'd0,3'd0}, {1'b1,3'd2,1'b0,3'd0,3'd0}, {1'b1,3'd2,1'b0,3'd0,3'd0},
    {1'b1,3'd2,1'b1,3'd2,3'd7}, {1'b1,3'd2,1'b0,3'd0,3'd0}, {1'b1,3'd2,1'b0,3'd0,3'd0},
    {1'b1,3'd2,1'b0,3'd0,3'd0}, {1'b1,3'd2,1'b0,3'd0,3'd0}, {1'b1,3'd2,1'b0,3'd0,3'd0},
    {1'b0,3'd0,1'b1,3'd2,3'd6}, {1'b0,3'd0,1'b0,3'd0,3'd0}, {1'b1,3'd4,1'b0,3'd0,3'd0},
    {1'b1,3'd6,1'b0,3'd0,3'd0}, {1'b1,3'd6,1'b0,3'd0,3'd0}, {1'b1,3'd4,1'b0,3'd0,3'd0},
    {1'b1,3'd1,1'b0,3'd0,3'd0}, {1'b1,3'd1,1'b0,3'd0,3'd0}, {1'b0,3'd0,1'b1,3'd6,3'd2}};

  // reference state
  int m_small [N];
  int m_wide [N];
  int m_cnt, m_best, m_bval;
  bit m_pend, m_ovf;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_small[i] = 0; m_wide[i] = 0; end
    m_cnt = 0; m_best = 0; m_bval = 0; m_pend = 0; m_ovf = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; inc_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk(flush_valid == 1'b0, "R1 flush_valid", flush_valid, 0);
    chk(ovf == 1'b0, "R1 ovf", ovf, 0);
    for (int i = 0; i < N; i++) begin
      rd_idx = 3'(i); #1;
      chk(rd_data == 0, "R1 wide zero", rd_data, 0);
    end
  endtask

  // one cycle: drive at a negedge, model it, check at the next negedge
  task automatic step(input bit v, input int idx);
    int e_fv, e_fi, e_fval, victim, lo;
    bit np;
    inc_valid = v; inc_idx = 3'(idx);
    e_fv = 0; e_fi = 0; e_fval = 0; np = 0;
    if (m_pend) begin
      lo = -1;
      for (int i = N - 1; i >= 0; i--) if (m_small[i] >= THR) lo = i;
      if (m_small[m_best] >= THR) victim = m_best;
      else if (lo >= 0) victim = lo;
      else victim = m_best;
      e_fv = 1; e_fi = victim; e_fval = m_small[victim];
      m_wide[victim] = (m_wide[victim] + m_small[victim]) % 4096;
      m_small[victim] = 0;
    end
    if (v) begin
      if (m_small[idx] == TOP) m_ovf = 1; else m_small[idx]++;
      if (m_cnt == 0 || m_small[idx] > m_bval) begin m_best = idx; m_bval = m_small[idx]; end
      m_cnt++;
      if (m_cnt == WIN) begin m_cnt = 0; np = 1; end
    end
    m_pend = np;
    @(negedge clk);
    chk(flush_valid == e_fv, "R3 flush timing", flush_valid, e_fv);
    if (e_fv != 0) begin
      chk(flush_idx == 3'(e_fi), "R4/R5/R6 victim", flush_idx, e_fi);
      chk(flush_val == 3'(e_fval), "R2/R7 flush value", flush_val, e_fval);
      rd_idx = 3'(e_fi); #1;
      chk(rd_data == 12'(m_wide[e_fi]), "R7 wide total", rd_data, m_wide[e_fi]);
    end
    chk(ovf == m_ovf, "R9 ovf", ovf, m_ovf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    do_reset();

    // table walk with hand-derived flushes
    for (int i = 0; i <= 32; i++) begin
      logic [10:0] e;
      e = VEC[i];
      inc_valid = e[10]; inc_idx = e[9:7];
      @(negedge clk);
      chk(flush_valid == e[6], "R3 table flush", flush_valid, e[6]);
      if (e[6]) begin
        chk(flush_idx == e[5:3], "R4/R5/R6 table victim", flush_idx, e[5:3]);
        chk(flush_val == e[2:0], "R7 table value", flush_val, e[2:0]);
      end
      chk(ovf == (i >= 17), "R9 table ovf", ovf, i >= 17);
    end
    inc_valid = 1'b0;

    // R10/R8: totals; counter 2 got 7 + 6, with no loss in the collision cycle
    begin
      int exp_w [N] = '{3, 0, 13, 0, 0, 3, 2, 0};
      for (int i = 0; i < N; i++) begin
        rd_idx = 3'(i); #1;
        chk(rd_data == 12'(exp_w[i]), "R8/R10 wide read", rd_data, exp_w[i]);
      end
    end

    // reset clears state, including sticky ovf (R1)
    do_reset();

    // R6 directed: two counters cross the threshold, the later one is flushed via the bitmap
    for (int i = 0; i < 3; i++) step(1, 1);
    for (int i = 0; i < 3; i++) step(1, 6);
    step(1, 0); step(1, 3); step(1, 0); step(1, 3); step(1, 4); step(1, 4);
    step(0, 0); step(0, 0);

    // concentrated pseudo-random traffic against the reference model
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      int idx;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      idx = lf[8] ? int'(lf[1:0]) : int'(lf[2:0]);
      step(lf[5:3] != 3'd0, idx);
    end
    step(0, 0); step(0, 0);
    for (int i = 0; i < N; i++) begin
      rd_idx = 3'(i); #1;
      chk(rd_data == 12'(m_wide[i]), "R10 final totals", rd_data, m_wide[i]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule